// File: doc/BRIEF.md
# Timing Reference Selector with Holdover

This block is the digital control core of a receiver clock. It watches several incoming timing references for rising edges and treats each one as usable only after it has shown steady activity for a qualification period. One usable reference is active and the others stand by. When the active reference goes quiet, the controller moves to the lowest-numbered standby reference that is still usable. The controller drives a frequency control word to a numerically controlled oscillator that sits outside the block.

While locked, the controller forwards the tracking word from an external phase detector and keeps a running average of it. If every reference is lost, the controller enters holdover and drives that average, which stops updating the moment the loss is declared. A configuration input selects the behaviour of the lowest clock class instead: on total loss the controller drops straight to free-run and drives the nominal oscillator word. Every change of the output word, whatever the cause, is slewed by at most a fixed step per cycle, so the phase moves slowly and downstream clocks stay locked.

The tracking word is sampled on every cycle and is never back-pressured. There is no valid/ready handshake at this port: the phase detector drives a fresh word each cycle, and a word the controller does not use in its current mode is simply ignored. The reference inputs are treated as asynchronous and are synchronized inside the block.

Top module: `tref_selector`

## Requirements
- R1: After reset the mode output is FREE_RUN (code 0), the frequency word equals NOMINAL, and the active index is 0.
- R2: A reference becomes usable after QUAL_CYC cycles of continuous activity. From FREE_RUN the block then enters SWITCHING (code 2) and reaches LOCKED (code 1) with the frequency word equal to the tracking word.
- R3: A reference is declared lost when LOSS_CYC local cycles pass with no rising edge. When the active reference is lost and another reference is usable, the active index moves to the lowest-numbered usable reference and the block locks to it.
- R4: When every reference is lost and the free-run option is clear, the mode becomes HOLDOVER (code 3), the active index is unchanged, and the frequency word settles within 2^AVG_SHIFT of the tracking word that was steady before the loss.
- R5: Once loss is declared, changes on the tracking word have no effect on the holdover frequency word.
- R6: With the free-run option set, total loss of references gives mode FREE_RUN (code 0), and the frequency word slews to NOMINAL.
- R7: When references return after holdover, the lowest-numbered usable reference becomes active, and the block goes through SWITCHING to LOCKED.
- R8: The frequency word changes by at most SLEW_STEP per cycle, and SWITCHING lasts until the word equals its target.
- R9: Activity that is shorter than the qualification period does not take the block out of HOLDOVER.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NREF | Timing reference inputs, asynchronous |
| track_word | input | FW | Tracking frequency word from the phase detector |
| freerun_only | input | 1 | Set: on total loss go to free-run instead of holdover |
| freq_word | output | FW | Slew-limited frequency control word |
| mode | output | 2 | 0 FREE_RUN, 1 LOCKED, 2 SWITCHING, 3 HOLDOVER |
| active_idx | output | IW | Index of the active reference |

## Verification
A corrupted qualification or gap counter shows up as a wrong mode or active index. This appears at the ports within a few tens of cycles of a reference starting or stopping, so the tests stop and start references and then read the mode and the index. A corrupted average appears only after a total loss, as a holdover word that drifts away from the last steady tracking value or follows the tracking word after loss. For that reason the tracking word is moved far off once loss has been declared. A broken slew stage shows up on the very next cycle as a step larger than SLEW_STEP, so a monitor compares the output word on every consecutive pair of cycles.

// File: rtl/tref_pkg.sv
package tref_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_LOCK   = 2'd1,
    MODE_SWITCH = 2'd2,
    MODE_HOLD   = 2'd3
  } tref_mode_e;
endpackage

// File: rtl/tref_act_mon.sv
module tref_act_mon #(
  parameter int LOSS_CYC = 20,
  parameter int QUAL_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_raw,
  output logic usable
);
  localparam int GW = $clog2(LOSS_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic [2:0]    sync_q;
  logic [GW-1:0] gap_q;
  logic [QW-1:0] qual_q;
  logic          rise, quiet;

  assign rise  = sync_q[1] & ~sync_q[2];
  assign quiet = (gap_q == GW'(LOSS_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      gap_q  <= GW'(LOSS_CYC);
      qual_q <= '0;
      usable <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ref_raw};
      if (rise)       gap_q <= '0;
      else if (!quiet) gap_q <= gap_q + 1'b1;
      if (quiet) begin
        qual_q <= '0;
        usable <= 1'b0;
      end else if (qual_q == QW'(QUAL_CYC)) begin
        usable <= 1'b1;
      end else begin
        qual_q <= qual_q + 1'b1;
      end
    end
  end

  // R3: a quiet reference is withdrawn on the next cycle
  p_lost_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> !usable);
endmodule

// File: rtl/tref_avg.sv
module tref_avg #(
  parameter int FW        = 24,
  parameter int AVG_SHIFT = 3,
  parameter logic [FW-1:0] NOMINAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [FW-1:0] sample,
  output logic [FW-1:0] avg
);
  logic signed [FW:0] delta, nudge, sum;

  assign delta = $signed({1'b0, sample}) - $signed({1'b0, avg});
  assign nudge = delta >>> AVG_SHIFT;
  assign sum   = $signed({1'b0, avg}) + nudge;

  always_ff @(posedge clk) begin
    if (!rst_n)      avg <= NOMINAL;
    else if (upd_en) avg <= sum[FW-1:0];
  end

  // R5: memory frozen whenever updates are disabled
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(avg));
endmodule

// File: rtl/tref_slew.sv
module tref_slew #(
  parameter int FW        = 24,
  parameter int SLEW_STEP = 4,
  parameter logic [FW-1:0] NOMINAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] target,
  output logic [FW-1:0] out_q,
  output logic          at_target
);
  localparam logic [FW-1:0] STEP = FW'(SLEW_STEP);

  logic [FW-1:0] gap_up, gap_dn;

  assign gap_up    = target - out_q;
  assign gap_dn    = out_q - target;
  assign at_target = (out_q == target);

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= NOMINAL;
    else if (target > out_q) out_q <= (gap_up > STEP) ? out_q + STEP : target;
    else if (target < out_q) out_q <= (gap_dn > STEP) ? out_q - STEP : target;
  end

  // R8: bounded rate of change in both directions
  p_slew_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q > $past(out_q)) |-> (out_q - $past(out_q) <= STEP));
  p_slew_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q < $past(out_q)) |-> ($past(out_q) - out_q <= STEP));
endmodule

// File: rtl/tref_selector.sv
module tref_selector
  import tref_pkg::*;
#(
  parameter int NREF      = 2,
  parameter int FW        = 24,
  parameter int LOSS_CYC  = 20,
  parameter int QUAL_CYC  = 40,
  parameter int AVG_SHIFT = 3,
  parameter int SLEW_STEP = 4,
  parameter logic [FW-1:0] NOMINAL = 24'h800000,
  localparam int IW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREF-1:0] ref_in,
  input  logic [FW-1:0]   track_word,
  input  logic            freerun_only,
  output logic [FW-1:0]   freq_word,
  output logic [1:0]      mode,
  output logic [IW-1:0]   active_idx
);
  tref_mode_e      st_q;
  logic [NREF-1:0] usable;
  logic [IW-1:0]   act_q, low_idx;
  logic            any_usable, act_ok, at_target, avg_en;
  logic [FW-1:0]   avg_word, target;

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    tref_act_mon #(.LOSS_CYC(LOSS_CYC), .QUAL_CYC(QUAL_CYC)) u_mon (
      .clk(clk), .rst_n(rst_n), .ref_raw(ref_in[g]), .usable(usable[g]));
  end

  always_comb begin
    low_idx = '0;
    for (int i = NREF - 1; i >= 0; i--)
      if (usable[i]) low_idx = IW'(i);
  end

  assign any_usable = |usable;
  assign act_ok     = usable[act_q];
  assign avg_en     = (st_q == MODE_LOCK) && act_ok;

  tref_avg #(.FW(FW), .AVG_SHIFT(AVG_SHIFT), .NOMINAL(NOMINAL)) u_avg (
    .clk(clk), .rst_n(rst_n), .upd_en(avg_en), .sample(track_word),
    .avg(avg_word));

  always_comb begin
    unique case (st_q)
      MODE_FREE: target = NOMINAL;
      MODE_HOLD: target = avg_word;
      default:   target = track_word;
    endcase
  end

  tref_slew #(.FW(FW), .SLEW_STEP(SLEW_STEP), .NOMINAL(NOMINAL)) u_slew (
    .clk(clk), .rst_n(rst_n), .target(target), .out_q(freq_word),
    .at_target(at_target));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= MODE_FREE;
      act_q <= '0;
    end else begin
      unique case (st_q)
        MODE_FREE, MODE_HOLD: begin
          if (any_usable) begin
            act_q <= low_idx;
            st_q  <= MODE_SWITCH;
          end else if (freerun_only) begin
            st_q <= MODE_FREE;
          end
        end
        default: begin
          if (!act_ok) begin
            if (any_usable) begin
              act_q <= low_idx;
              st_q  <= MODE_SWITCH;
            end else begin
              st_q <= freerun_only ? MODE_FREE : MODE_HOLD;
            end
          end else if (st_q == MODE_SWITCH && at_target) begin
            st_q <= MODE_LOCK;
          end
        end
      endcase
    end
  end

  assign mode       = st_q;
  assign active_idx = act_q;

  // R3: a lost active reference never leaves the block locked
  p_locked_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MODE_LOCK && !act_ok) |=> (st_q != MODE_LOCK));
  // R8: switching finishes once the slewed word meets its target
  p_switch_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MODE_SWITCH && act_ok && at_target) |=> (st_q == MODE_LOCK));
endmodule

// File: tb/sim_tref_selector.sv
module sim_tref_selector;
  localparam int NREF = 2;
  localparam int FW   = 24;
  localparam int STEP = 4;
  localparam logic [FW-1:0] NOM = 24'h800000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREF-1:0] ref_in = '0;
  logic [NREF-1:0] ref_en = '0;
  logic [FW-1:0] track_word = NOM;
  logic freerun_only = 1'b0;
  logic [FW-1:0] freq_word;
  logic [1:0] mode;
  logic [0:0] active_idx;

  int checks = 0, errors = 0;
  int slew_bad = 0;
  bit seen_switch = 0;
  bit done = 0;
  logic [FW-1:0] prev_freq = NOM;
  int ph = 0;

  always #10 clk = ~clk;

  tref_selector u0 (.clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .track_word(track_word), .freerun_only(freerun_only),
    .freq_word(freq_word), .mode(mode), .active_idx(active_idx));

  // reference generator: period of 8 local cycles when enabled
  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    if (ph == 0) ref_in <= ref_in ^ ref_en;
  end

  // slew monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if ((freq_word > prev_freq && freq_word - prev_freq > STEP) ||
          (freq_word < prev_freq && prev_freq - freq_word > STEP))
        slew_bad++;
      if (mode == 2'd2) seen_switch = 1;
    end
    prev_freq = freq_word;
  end

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check(mode == 2'd0, "R1 mode", mode, 0);
    check(freq_word == NOM, "R1 freq", freq_word, NOM);
    check(active_idx == 0, "R1 index", active_idx, 0);
  endtask

  task automatic t_lock;
    track_word = NOM + 200;
    seen_switch = 0;
    ref_en = 2'b01;
    wait_cyc(200);
    check(seen_switch, "R2 passed through SWITCHING", seen_switch, 1);
    check(mode == 2'd1, "R2 mode", mode, 1);
    check(freq_word == track_word, "R2 freq", freq_word, track_word);
  endtask

  task automatic t_failover;
    ref_en = 2'b11;
    wait_cyc(100);
    ref_en = 2'b10;
    wait_cyc(80);
    check(active_idx == 1, "R3 index", active_idx, 1);
    check(mode == 2'd1, "R3 mode", mode, 1);
  endtask

  task automatic t_holdover;
    track_word = NOM + 300;
    wait_cyc(150);
    ref_en = 2'b00;
    wait_cyc(45);
    track_word = NOM + 1300;
    wait_cyc(200);
    check(mode == 2'd3, "R4 mode", mode, 3);
    check(active_idx == 1, "R4 index", active_idx, 1);
    check(freq_word <= NOM + 300 && freq_word + 8 > NOM + 300,
          "R5 holdover word frozen", freq_word, NOM + 300);
  endtask

  task automatic t_glitch;
    ref_en = 2'b10;
    wait_cyc(20);
    ref_en = 2'b00;
    wait_cyc(80);
    check(mode == 2'd3, "R9 short activity ignored", mode, 3);
  endtask

  task automatic t_restore;
    seen_switch = 0;
    ref_en = 2'b11;
    wait_cyc(400);
    check(active_idx == 0, "R7 lowest index", active_idx, 0);
    check(mode == 2'd1 && seen_switch, "R7 mode via SWITCHING", mode, 1);
    check(freq_word == track_word, "R7 freq", freq_word, track_word);
  endtask

  task automatic t_freerun;
    freerun_only = 1'b1;
    ref_en = 2'b00;
    wait_cyc(450);
    check(mode == 2'd0, "R6 mode", mode, 0);
    check(freq_word == NOM, "R6 freq", freq_word, NOM);
  endtask

  initial begin
    t_reset;
    t_lock;
    t_failover;
    t_holdover;
    t_glitch;
    t_restore;
    t_freerun;
    check(slew_bad == 0, "R8 slew bound", slew_bad, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule